// File: doc/BRIEF.md
# PWM Interrupt Flag Controller

This block gathers the interrupt sources of one PWM generator and drives a single interrupt request line toward a central interrupt unit. It watches the end-of-period strobe from the period counter and the pulse that marks a change of operating mode. It applies the software-written enables, the period prescale value and the flag-clear bit to these events, and presents a small status word together with the request line.

The period interrupt passes through a programmable divider, so software can ask for one interrupt per period or one per up to 256 periods. The flag it produces lasts one cycle and is not latched. The mode-switch flag is sticky. Software removes it by raising the clear bit from 0 to 1. The request line is registered and carries the OR of every flag that is both set and enabled.

Top module: `pwm_irq_ctrl`

## Requirements
- R1: While `pwm_en` is high, the period flag (`status[0]`) is high for exactly one cycle, in the cycle after a `period_end` pulse that completes a prescale group. In every other cycle it is low.
- R2: With prescale value N on `prd_scale` (8 bits, 0 to 255), one period flag is produced for every N+1 `period_end` pulses. The first flag comes on pulse N+1 after reset, after a prescale write, or after the PWM is enabled.
- R3: A cycle with `prd_scale_wr` high restarts the prescale count at zero. A `period_end` pulse in that same cycle is not counted and raises no flag.
- R4: While `pwm_en` is low, the period flag is high in every cycle and the prescale count is held at zero.
- R5: A `mode_evt` pulse sets the mode-switch flag (`status[1]`) in the next cycle. The flag then stays high without further events until it is cleared.
- R6: The mode-switch flag is cleared only in the cycle after a 0-to-1 transition of `mode_clr`. Holding `mode_clr` high does not clear events that arrive later.
- R7: If a `mode_evt` pulse and a clear edge fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when the period flag is high with `prd_irq_en` high at the preceding edge, or the mode-switch flag is high with `mode_irq_en` high at the preceding edge. It changes in the same cycle as the flags.
- R9: `status[2]` mirrors `irq`. After reset, `status` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_en | input | 1 | PWM generator running |
| period_end | input | 1 | End-of-period strobe from the period counter |
| mode_evt | input | 1 | One-cycle pulse marking a mode change |
| prd_irq_en | input | 1 | Enable for the period interrupt |
| mode_irq_en | input | 1 | Enable for the mode-switch interrupt |
| prd_scale | input | SCALE_W | Period prescale value N (one interrupt per N+1 periods) |
| prd_scale_wr | input | 1 | Write strobe for the prescale field; restarts the count |
| mode_clr | input | 1 | Mode-switch flag clear bit, acting on its rising edge |
| status | output | 3 | {irq, mode-switch flag, period flag} |
| irq | output | 1 | Registered interrupt request to the central unit |

## Verification
Two pairs of functions can land in one cycle. A mode-change pulse can coincide with the rising edge of the clear bit, and a prescale write can coincide with the period pulse that would have closed a group. The bench raises both inputs in the same cycle for each pair. In the first case it expects the flag to stay set, and in the second it expects no period flag and a full new group of N+1 pulses before the next one. The bench also holds the clear bit high across a later event, to show that only the edge clears the flag.

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_en,
  input  logic               period_end,
  input  logic               mode_evt,
  input  logic               prd_irq_en,
  input  logic               mode_irq_en,
  input  logic [SCALE_W-1:0] prd_scale,
  input  logic               prd_scale_wr,
  input  logic               mode_clr,
  output logic [2:0]         status,
  output logic               irq
);

  logic [SCALE_W-1:0] cnt;
  logic prd_flag, mode_flag, clr_q;
  logic group_done, prd_next, clr_edge, mode_next, irq_next;

  assign group_done = period_end && (cnt == prd_scale);
  assign prd_next   = !pwm_en || (group_done && !prd_scale_wr);
  assign clr_edge   = mode_clr && !clr_q;
  assign mode_next  = mode_evt || (mode_flag && !clr_edge);
  assign irq_next   = (prd_next && prd_irq_en) || (mode_next && mode_irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (prd_scale_wr || !pwm_en) begin
      cnt <= '0;
    end else if (period_end) begin
      cnt <= group_done ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_flag  <= 1'b0;
      mode_flag <= 1'b0;
      clr_q     <= 1'b0;
      irq       <= 1'b0;
    end else begin
      prd_flag  <= prd_next;
      mode_flag <= mode_next;
      clr_q     <= mode_clr;
      irq       <= irq_next;
    end
  end

  assign status = {irq, mode_flag, prd_flag};

  // period flag while running only follows a period pulse
  assert_prd_from_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_flag && $past(pwm_en)) |-> $past(period_end));

  assert_prd_held_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pwm_en)) |-> prd_flag);

  assert_mode_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_evt) |-> mode_flag);

  // a falling mode flag needs a clear edge (R6)
  assert_mode_clear_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_flag) |-> ($past(mode_clr) && !$past(clr_q)));

  assert_irq_aggregate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((prd_flag && $past(prd_irq_en)) || (mode_flag && $past(mode_irq_en))));

  assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwm_en) && !$past(prd_scale_wr) && $past(period_end) && $past(cnt == prd_scale)) |-> (cnt == '0));

endmodule

// File: tb/test_pwm_irq_ctrl.sv
`timescale 1ns/1ps
module test_pwm_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_en = 1'b0, period_end = 1'b0, mode_evt = 1'b0;
  logic prd_irq_en = 1'b0, mode_irq_en = 1'b0;
  logic [7:0] prd_scale = 8'd0;
  logic prd_scale_wr = 1'b0, mode_clr = 1'b0;
  logic [2:0] status;
  logic irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  pwm_irq_ctrl #(.SCALE_W(8)) i_pwm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .period_end(period_end),
    .mode_evt(mode_evt), .prd_irq_en(prd_irq_en), .mode_irq_en(mode_irq_en),
    .prd_scale(prd_scale), .prd_scale_wr(prd_scale_wr), .mode_clr(mode_clr),
    .status(status), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_scale(input logic [7:0] n);
    prd_scale = n; prd_scale_wr = 1'b1;
    tick();
    prd_scale_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 reset status", status, 3'b000);
    check("R9 reset irq", irq, 1'b0);
  endtask

  task automatic t_disabled();
    pwm_en = 1'b0; prd_irq_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R4 prd held while disabled", status[0], 1'b1);
      check("R8 masked irq", irq, 1'b0);
    end
    prd_irq_en = 1'b1;
    tick();
    check("R4 continuous irq while disabled", irq, 1'b1);
    check("R9 status mirrors irq", status[2], 1'b1);
    prd_irq_en = 1'b0;
  endtask

  task automatic t_prescale(input logic [7:0] n, input int groups);
    pwm_en = 1'b1; prd_irq_en = 1'b1;
    set_scale(n);
    tick();
    check("R1 prd low after enable", status[0], 1'b0);
    for (int g = 0; g < groups; g++) begin
      for (int k = 0; k <= int'(n); k++) begin
        period_end = 1'b1;
        tick();
        period_end = 1'b0;
        check("R2 prd per N+1 periods", status[0], (k == int'(n)));
        check("R8 irq with period flag", irq, (k == int'(n)));
        if (n < 8'd4) begin
          tick();
          check("R1 strobe lasts one cycle", status[0], 1'b0);
        end
      end
    end
    prd_irq_en = 1'b0;
  endtask

  task automatic t_back_to_back();
    pwm_en = 1'b1;
    set_scale(8'd0);
    period_end = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R2 scale 0 every period", status[0], 1'b1);
    end
    period_end = 1'b0;
    tick();
    check("R1 no pulse no flag", status[0], 1'b0);
  endtask

  task automatic t_write_collide();
    pwm_en = 1'b1;
    set_scale(8'd1);
    period_end = 1'b1; tick(); period_end = 1'b0;
    check("R3 first of two", status[0], 1'b0);
    period_end = 1'b1; prd_scale_wr = 1'b1; tick();
    period_end = 1'b0; prd_scale_wr = 1'b0;
    check("R3 write swallows pulse", status[0], 1'b0);
    period_end = 1'b1; tick(); period_end = 1'b0;
    check("R3 count restarted", status[0], 1'b0);
    period_end = 1'b1; tick(); period_end = 1'b0;
    check("R3 full group after write", status[0], 1'b1);
  endtask

  task automatic t_reenable();
    set_scale(8'd2);
    pwm_en = 1'b1;
    period_end = 1'b1; tick();
    period_end = 1'b0; pwm_en = 1'b0; tick();
    check("R4 flag while disabled", status[0], 1'b1);
    pwm_en = 1'b1; tick();
    for (int k = 0; k < 3; k++) begin
      period_end = 1'b1; tick(); period_end = 1'b0;
      check("R4 count zeroed by disable", status[0], (k == 2));
    end
  endtask

  task automatic t_mode();
    mode_irq_en = 1'b1; prd_irq_en = 1'b0; pwm_en = 1'b1; mode_clr = 1'b0;
    tick();
    check("R8 idle irq low", irq, 1'b0);
    mode_evt = 1'b1; tick(); mode_evt = 1'b0;
    check("R5 flag set", status[1], 1'b1);
    check("R8 irq with mode flag", irq, 1'b1);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5 flag sticky", status[1], 1'b1);
    end
    mode_clr = 1'b1; tick();
    check("R6 edge clears", status[1], 1'b0);
    check("R8 irq falls with flag", irq, 1'b0);
    mode_evt = 1'b1; tick(); mode_evt = 1'b0;
    check("R6 held clear lets set", status[1], 1'b1);
    tick(); tick();
    check("R6 held clear does not clear", status[1], 1'b1);
    mode_clr = 1'b0; tick();
    check("R6 falling clear no effect", status[1], 1'b1);
    mode_clr = 1'b1; mode_evt = 1'b1; tick(); mode_evt = 1'b0;
    check("R7 set wins over clear", status[1], 1'b1);
    tick();
    check("R7 flag kept after collision", status[1], 1'b1);
    mode_irq_en = 1'b0; tick();
    check("R8 enable off masks irq", irq, 1'b0);
    check("R9 status irq bit", status[2], 1'b0);
    mode_irq_en = 1'b1; tick();
    check("R8 enable on raises irq", irq, 1'b1);
    mode_clr = 1'b0; tick(); mode_clr = 1'b1; tick();
    check("R6 second edge clears", status[1], 1'b0);
    mode_clr = 1'b0; mode_irq_en = 1'b0;
  endtask

  initial begin
    #1;
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    t_disabled();
    t_prescale(8'd2, 2);
    t_prescale(8'd255, 1);
    t_back_to_back();
    t_write_collide();
    t_reenable();
    t_mode();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule